// File: doc/BRIEF.md
# Data-Enable Gated Blanking Inserter

This block sits on a three-channel pixel path (channel 0 carries Y or G, channels 1 and 2 carry the two colour-difference or remaining colour components). Every sample passes through one pipeline register. When gating is active and the data-enable signal is low, each channel is replaced by a blanking level instead. The blanking level depends on a colour-space input. In RGB mode every channel blanks to zero. In YPbPr mode channel 0 blanks to zero and channels 1 and 2 blank to mid-scale.

A single shared input pin has one of three uses, selected by a control input and the timing mode. It can be a field-identifier input that is forwarded to the field output. In PC timing mode it can be a data-enable input that drives the gating. In SD or HD timing mode with separate syncs the pin can be ignored altogether, and the field identifier is then derived inside the block. The derived value depends on where the rising edge of vertical sync falls relative to the last rising edge of horizontal sync.

The data path and the field output pass through the same single register stage, so they stay aligned with each other.

Top module: `pixgate_top`

## Requirements
- R1: With `pin_is_en_i`=0, in any timing mode, `fid_o` equals the value `fld_i` had one clock earlier, and all three channels pass through unchanged with one clock of latency.
- R2: With `pin_is_en_i`=1 and `tmode_i`=2'b00 (PC mode), a high `fld_i` lets the samples of that cycle pass to the outputs unchanged one clock later.
- R3: With `pin_is_en_i`=1 and `tmode_i`=2'b00, a low `fld_i` replaces the samples of that cycle by blanking levels one clock later, and `fid_o` is 0 one clock later regardless of `fld_i`.
- R4: With `rgb_i`=1 (RGB), the blanking level is 0 on all three channels.
- R5: With `rgb_i`=0 (YPbPr), the blanking level is 0 on channel 0 and 2^(CH_W-1) on channels 1 and 2 (1024 for 11-bit channels).
- R6: With `pin_is_en_i`=1 and `tmode_i` in {2'b01 SD, 2'b10 HD, 2'b11 treated as HD}, `fld_i` is ignored. Samples always pass unchanged, and one clock later `fid_o` equals the internally derived field ID.
- R7: At a rising edge of `vs_i`, the internal field ID becomes 0 if `vs_i` rises within ALIGN_TOL clocks after the latest rising edge of `hs_i`, counting the same clock as 0.
- R8: At a rising edge of `vs_i` more than ALIGN_TOL clocks after the latest `hs_i` rising edge, the internal field ID becomes 1. It holds its value until the next `vs_i` rising edge.
- R9: While `rst` is high, all channel outputs and `fid_o` are 0 and the internal field ID is cleared to 0.
- R10: Data and field outputs share a single register stage, so a data-enable that toggles every clock blanks exactly the samples that arrived with it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ch0_i | input | CH_W | Channel 0 sample (Y or G) |
| ch1_i | input | CH_W | Channel 1 sample (Pb or B) |
| ch2_i | input | CH_W | Channel 2 sample (Pr or R) |
| fld_i | input | 1 | Shared pin: field ID or data enable |
| pin_is_en_i | input | 1 | Shared-pin role select (0 selects field-ID use) |
| rgb_i | input | 1 | Colour space for blanking (1 RGB, 0 YPbPr) |
| tmode_i | input | 2 | Timing mode: 00 PC, 01 SD, 10 HD, 11 HD |
| hs_i | input | 1 | Horizontal sync, active high |
| vs_i | input | 1 | Vertical sync, active high |
| ch0_o | output | CH_W | Gated channel 0 |
| ch1_o | output | CH_W | Gated channel 1 |
| ch2_o | output | CH_W | Gated channel 2 |
| fid_o | output | 1 | Effective field ID |

## Verification
The bench sweeps every combination of timing mode, pin role, colour space and pin level, using several sample patterns that include zero, full scale and mid-scale. Comparing blanked outputs with pass-through outputs shows which channel takes which blanking level, and confirms that the pin gates data only in PC mode. The pin toggles every clock so that a one-cycle skew between enable and data shows up. For the internally derived field ID, vertical sync is placed at 0, ALIGN_TOL, ALIGN_TOL+1 and mid-line offsets from horizontal sync. This separates the edge of the tolerance window from its inside, and a second sweep then confirms that the field output follows the derived value rather than the pin.

// File: rtl/pixgate_pkg.sv
package pixgate_pkg;

    localparam int PG_CH_W      = 11;
    localparam int PG_PH_W      = 13;
    localparam int PG_ALIGN_TOL = 4;

    typedef enum logic [1:0] {
        TM_PC  = 2'b00,
        TM_SD  = 2'b01,
        TM_HD  = 2'b10,
        TM_HDX = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        FS_PIN  = 2'b00,
        FS_ZERO = 2'b01,
        FS_INT  = 2'b10
    } fid_src_e;

    typedef struct packed {
        logic     gate_en;
        logic     rgb;
        fid_src_e fid_src;
    } cfg_t;

    function automatic cfg_t pg_decode(input logic pin_is_en, input logic rgb, input tmode_e mode);
        cfg_t c;
        c.rgb = rgb;
        if (!pin_is_en) begin
            c.gate_en = 1'b0;
            c.fid_src = FS_PIN;
        end else if (mode == TM_PC) begin
            c.gate_en = 1'b1;
            c.fid_src = FS_ZERO;
        end else begin
            c.gate_en = 1'b0;
            c.fid_src = FS_INT;
        end
        return c;
    endfunction

endpackage

// File: rtl/pixgate_fidgen.sv
module pixgate_fidgen #(
    parameter int PH_W      = pixgate_pkg::PG_PH_W,
    parameter int ALIGN_TOL = pixgate_pkg::PG_ALIGN_TOL
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_i,
    input  logic vs_i,
    output logic fid_o
);
    localparam logic [PH_W-1:0] PH_MAX = {PH_W{1'b1}};
    localparam logic [PH_W-1:0] PH_TOL = PH_W'(ALIGN_TOL);

    logic            hs_d, vs_d, fid_q;
    logic            hs_rise, vs_rise;
    logic [PH_W-1:0] ph_q, ph_now;

    assign hs_rise = hs_i & ~hs_d;
    assign vs_rise = vs_i & ~vs_d;
    // distance in clocks from the latest HS rising edge
    assign ph_now  = hs_rise ? '0 : ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_d  <= 1'b0;
            vs_d  <= 1'b0;
            ph_q  <= PH_MAX;
            fid_q <= 1'b0;
        end else begin
            hs_d <= hs_i;
            vs_d <= vs_i;
            if (hs_rise)
                ph_q <= PH_W'(1);
            else if (ph_q != PH_MAX)
                ph_q <= ph_q + PH_W'(1);
            if (vs_rise)
                fid_q <= (ph_now > PH_TOL);
        end
    end

    assign fid_o = fid_q;
endmodule

// File: rtl/pixgate_gate.sv
module pixgate_gate #(
    parameter int CH_W = pixgate_pkg::PG_CH_W,
    parameter int N_CH = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_CH-1:0][CH_W-1:0] pix_i,
    input  logic                      de_i,
    input  logic                      rgb_i,
    output logic [N_CH-1:0][CH_W-1:0] pix_o
);
    localparam logic [CH_W-1:0] LVL_MID = CH_W'(1) << (CH_W - 1);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic [CH_W-1:0] blank, pix_q;
        // channel 0 is luma/green: bottom-of-range in both colour spaces
        if (g == 0) begin : g_luma
            assign blank = '0;
        end else begin : g_chroma
            assign blank = rgb_i ? '0 : LVL_MID;
        end
        always_ff @(posedge clk) begin
            if (rst)
                pix_q <= '0;
            else
                pix_q <= de_i ? pix_i[g] : blank;
        end
        assign pix_o[g] = pix_q;
    end
endmodule

// File: rtl/pixgate_top.sv
module pixgate_top
    import pixgate_pkg::*;
#(
    parameter int CH_W      = PG_CH_W,
    parameter int PH_W      = PG_PH_W,
    parameter int ALIGN_TOL = PG_ALIGN_TOL
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CH_W-1:0] ch0_i,
    input  logic [CH_W-1:0] ch1_i,
    input  logic [CH_W-1:0] ch2_i,
    input  logic            fld_i,
    input  logic            pin_is_en_i,
    input  logic            rgb_i,
    input  logic [1:0]      tmode_i,
    input  logic            hs_i,
    input  logic            vs_i,
    output logic [CH_W-1:0] ch0_o,
    output logic [CH_W-1:0] ch1_o,
    output logic [CH_W-1:0] ch2_o,
    output logic            fid_o
);
    cfg_t                 cfg;
    logic                 de, fid_int, fid_next, fid_q;
    logic [2:0][CH_W-1:0] pix_in, pix_out;

    assign cfg    = pg_decode(pin_is_en_i, rgb_i, tmode_e'(tmode_i));
    assign de     = cfg.gate_en ? fld_i : 1'b1;
    assign pix_in = {ch2_i, ch1_i, ch0_i};

    pixgate_gate #(.CH_W(CH_W), .N_CH(3)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .pix_i (pix_in),
        .de_i  (de),
        .rgb_i (cfg.rgb),
        .pix_o (pix_out)
    );

    pixgate_fidgen #(.PH_W(PH_W), .ALIGN_TOL(ALIGN_TOL)) u_fid (
        .clk   (clk),
        .rst   (rst),
        .hs_i  (hs_i),
        .vs_i  (vs_i),
        .fid_o (fid_int)
    );

    always_comb begin
        case (cfg.fid_src)
            FS_PIN:  fid_next = fld_i;
            FS_INT:  fid_next = fid_int;
            default: fid_next = 1'b0;
        endcase
    end

    // same single stage as the data path keeps field and pixels aligned
    always_ff @(posedge clk) begin
        if (rst)
            fid_q <= 1'b0;
        else
            fid_q <= fid_next;
    end

    assign ch0_o = pix_out[0];
    assign ch1_o = pix_out[1];
    assign ch2_o = pix_out[2];
    assign fid_o = fid_q;
endmodule

// File: rtl/pixgate_chk.sv
module pixgate_chk #(
    parameter int CH_W = 11
) (
    input logic            clk,
    input logic            rst,
    input logic [CH_W-1:0] ch0_i,
    input logic [CH_W-1:0] ch1_i,
    input logic [CH_W-1:0] ch2_i,
    input logic            fld_i,
    input logic            pin_is_en_i,
    input logic            rgb_i,
    input logic [1:0]      tmode_i,
    input logic            hs_i,
    input logic            vs_i,
    input logic [CH_W-1:0] ch0_o,
    input logic [CH_W-1:0] ch1_o,
    input logic [CH_W-1:0] ch2_o,
    input logic            fid_o,
    input logic            fid_int
);
    localparam logic [CH_W-1:0] MID = CH_W'(1) << (CH_W - 1);

    logic hs_q, vs_q, pc_gate;
    assign pc_gate = pin_is_en_i && (tmode_i == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hs_i;
            vs_q <= vs_i;
        end
    end

    assert_fid_pass_R1: assert property (@(posedge clk) disable iff (rst)
        !pin_is_en_i |=> (fid_o == $past(fld_i)) && (ch0_o == $past(ch0_i))
                         && (ch1_o == $past(ch1_i)) && (ch2_o == $past(ch2_i)));

    assert_de_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (pc_gate && fld_i) |=> (ch0_o == $past(ch0_i)) && (ch1_o == $past(ch1_i))
                               && (ch2_o == $past(ch2_i)));

    assert_fid_zero_R3: assert property (@(posedge clk) disable iff (rst)
        pc_gate |=> !fid_o);

    assert_blank_rgb_R4: assert property (@(posedge clk) disable iff (rst)
        (pc_gate && !fld_i && rgb_i) |=> (ch0_o == '0) && (ch1_o == '0) && (ch2_o == '0));

    assert_blank_ypbpr_R5: assert property (@(posedge clk) disable iff (rst)
        (pc_gate && !fld_i && !rgb_i) |=> (ch0_o == '0) && (ch1_o == MID) && (ch2_o == MID));

    assert_pin_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (pin_is_en_i && tmode_i != 2'b00) |=> (fid_o == $past(fid_int))
            && (ch0_o == $past(ch0_i)) && (ch1_o == $past(ch1_i)) && (ch2_o == $past(ch2_i)));

    assert_fid_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        (vs_i && !vs_q && hs_i && !hs_q) |=> !fid_int);

    assert_fid_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(vs_i && !vs_q) |=> $stable(fid_int));
endmodule

bind pixgate_top pixgate_chk #(.CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ch0_i       (ch0_i),
    .ch1_i       (ch1_i),
    .ch2_i       (ch2_i),
    .fld_i       (fld_i),
    .pin_is_en_i (pin_is_en_i),
    .rgb_i       (rgb_i),
    .tmode_i     (tmode_i),
    .hs_i        (hs_i),
    .vs_i        (vs_i),
    .ch0_o       (ch0_o),
    .ch1_o       (ch1_o),
    .ch2_o       (ch2_o),
    .fid_o       (fid_o),
    .fid_int     (fid_int)
);

// File: tb/sim_pixgate_top.sv
`timescale 1ns/1ps
module sim_pixgate_top;
    localparam int CH_W = 11;
    localparam int TOL  = 4;
    localparam int LINE = 20;
    localparam logic [CH_W-1:0] MID = 11'd1024;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [CH_W-1:0] ch0_i = '0, ch1_i = '0, ch2_i = '0;
    logic            fld_i = 1'b0, pin_is_en_i = 1'b0, rgb_i = 1'b1;
    logic [1:0]      tmode_i = 2'b00;
    logic            hs_i = 1'b0, vs_i = 1'b0;
    logic [CH_W-1:0] ch0_o, ch1_o, ch2_o;
    logic            fid_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic fid_model = 1'b0;

    always #2.5 clk = ~clk;

    pixgate_top #(.CH_W(CH_W), .PH_W(13), .ALIGN_TOL(TOL)) u0 (
        .clk(clk), .rst(rst), .ch0_i(ch0_i), .ch1_i(ch1_i), .ch2_i(ch2_i),
        .fld_i(fld_i), .pin_is_en_i(pin_is_en_i), .rgb_i(rgb_i), .tmode_i(tmode_i),
        .hs_i(hs_i), .vs_i(vs_i), .ch0_o(ch0_o), .ch1_o(ch1_o), .ch2_o(ch2_o), .fid_o(fid_o)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            summary();
        end
    end

    // full sweep of mode/role/colour/pin, checked every clock against the previous inputs
    task automatic sweep();
        logic have = 1'b0;
        logic [CH_W-1:0] e0 = '0, e1 = '0, e2 = '0;
        logic ef = 1'b0;
        string rq = "";
        for (int m = 0; m < 4; m++)
            for (int en = 0; en < 2; en++)
                for (int cs = 0; cs < 2; cs++)
                    for (int k = 0; k < 8; k++) begin
                        logic [CH_W-1:0] d0, d1, d2;
                        logic pin, gate;
                        @(negedge clk);
                        if (have) begin
                            chk({rq, " ch0"}, ch0_o, e0);
                            chk({rq, " ch1"}, ch1_o, e1);
                            chk({rq, " ch2"}, ch2_o, e2);
                            chk({rq, " fid"}, fid_o, ef);
                        end
                        pin = k[0];
                        d0 = (k == 1) ? '1 : CH_W'(k * 389 + m * 97 + 5);
                        d1 = (k == 3) ? MID : CH_W'(k * 611 + cs * 201 + 3);
                        d2 = (k == 5) ? '0 : CH_W'(k * 173 + en * 55 + 9);
                        tmode_i = m[1:0]; pin_is_en_i = en[0]; rgb_i = cs[0];
                        fld_i = pin; ch0_i = d0; ch1_i = d1; ch2_i = d2;
                        gate = en[0] && (m == 0);
                        have = 1'b1;
                        if (gate && !pin) begin
                            rq = cs[0] ? "R3/R4/R10 blank rgb" : "R3/R5/R10 blank ypbpr";
                            e0 = '0;
                            e1 = cs[0] ? '0 : MID;
                            e2 = cs[0] ? '0 : MID;
                        end else begin
                            rq = gate ? "R2/R10 pass" : (en[0] ? "R6 pin ignored" : "R1 fid mode pass");
                            e0 = d0; e1 = d1; e2 = d2;
                        end
                        ef = !en[0] ? pin : ((m == 0) ? 1'b0 : fid_model);
                    end
        @(negedge clk);
        chk({rq, " ch0"}, ch0_o, e0);
        chk({rq, " ch1"}, ch1_o, e1);
        chk({rq, " ch2"}, ch2_o, e2);
        chk({rq, " fid"}, fid_o, ef);
    endtask

    task automatic lines(input int n, input int vs_off);
        for (int l = 0; l < n; l++)
            for (int p = 0; p < LINE; p++) begin
                @(negedge clk);
                hs_i = (p < 2);
                if (vs_off >= 0 && l == 0 && p == vs_off) vs_i = 1'b1;
            end
    endtask

    task automatic run_fid(input int mode, input int off, input logic exp, input string rq);
        tmode_i = mode[1:0]; pin_is_en_i = 1'b1; vs_i = 1'b0;
        lines(2, -1);
        lines(2, off);
        chk({rq, " fid after vs"}, fid_o, exp);
        vs_i = 1'b0;
        fld_i = ~exp;
        lines(2, -1);
        chk({"R8 hold ", rq}, fid_o, exp);
        fid_model = exp;
    endtask

    initial begin
        ch0_i = 11'd777; ch1_i = 11'd333; ch2_i = 11'd555; fld_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 reset ch0", ch0_o, 0);
        chk("R9 reset ch1", ch1_o, 0);
        chk("R9 reset ch2", ch2_o, 0);
        chk("R9 reset fid", fid_o, 0);
        rst = 1'b0;
        sweep();
        // internal fid: flip it at every step to separate tolerance edge from interior
        run_fid(1, 10, 1'b1, "R8 mid-line");
        run_fid(1, 0, 1'b0, "R7 coincident");
        run_fid(2, TOL + 1, 1'b1, "R8 just outside tol");
        run_fid(2, TOL, 1'b0, "R7 at tol edge");
        run_fid(3, 9, 1'b1, "R6/R8 mode 11");
        sweep();
        summary();
    end
endmodule